// File: doc/BRIEF.md
# Serial Flash Block-Move Engine

This block moves a run of bytes between system memory and the data lanes of a serial NAND flash controller, so the processor does not have to copy them. Software writes the memory start address and a byte count, then writes the trigger register. The value written to the trigger picks the direction. The engine then talks to a 32-bit memory port with a request/ready handshake, and to a byte-wide serial phase port that it shares with the programmed I/O engine. When the last byte has moved, the engine sets a pending bit. That bit drives the interrupt line if the enable bit in the config register is set.

The two directions have different ceilings. A flash-to-memory run moves at most 2080 bytes, and a memory-to-flash run moves at most 520 bytes. A larger count is cut down to the ceiling of the chosen direction. Memory is always accessed as aligned words. The first byte of the stream sits in bits 31:24 of a word. A short final word written to memory carries byte enables only for the bytes it holds.

Top module: `snand_dma`

## Requirements
- R1: After reset the interrupt is low, no memory request or serial handshake is active, and the config, address, length, pending and busy readbacks are all zero.
- R2: Register map. Config is at 0x00, and bit 20 is the interrupt enable. The start address is at 0x1C and is a full 32-bit register. The length register is at 0x24: the byte count is in bits 11:0 and the lane code (lane count divided by two) is in bits 29:28. Each register reads back what was written to those fields.
- R3: Writing to the trigger at 0x18 starts a run. Data bit 0 selects the direction: 0 moves flash to memory and 1 moves memory to flash.
- R4: Words are transferred at consecutive aligned addresses, starting at the start address with its two low bits cleared. Stream byte k occupies bits 31-8*(k mod 4) down to 24-8*(k mod 4) of word k/4.
- R5: In a flash-to-memory run, mem_be bit 3 covers bits 31:24 and bit 0 covers bits 7:0. A short final word enables only its filled bytes, and its unfilled bytes are written as zero.
- R6: A flash-to-memory count above 2080 is reduced to 2080 bytes.
- R7: A memory-to-flash count above 520 is reduced to 520 bytes.
- R8: Bit 0 of the status register at 0x20 becomes 1 when a run completes. Writing 1 to it clears it. Writing 0 to it leaves it unchanged.
- R9: irq is 1 exactly when the pending bit and the config enable are both 1.
- R10: The register at 0x40 reads bits 3:1 as 1 while a run is active, and reads 0 when idle.
- R11: A trigger write made while a run is active is ignored: the run in progress keeps its direction and byte count.
- R12: A count of zero completes at once, with no memory or serial transfer, and still sets the pending bit.
- R13: While a run is active, fl_width shows the lane code captured at the trigger and fl_dir shows the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write to memory, 0 = read from memory |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_ready | input | 1 | Memory accepts or completes the access this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| fl_rx_valid | input | 1 | Serial side offers a byte read from flash |
| fl_rx_data | input | 8 | Byte read from flash |
| fl_rx_ready | output | 1 | Engine takes the offered flash byte |
| fl_tx_valid | output | 1 | Engine offers a byte for flash |
| fl_tx_data | output | 8 | Byte to be written to flash |
| fl_tx_ready | input | 1 | Serial side takes the offered byte |
| fl_own | output | 1 | Engine owns the serial phase port |
| fl_dir | output | 1 | Direction of the active run |
| fl_width | output | 2 | Lane code of the active run |
| irq | output | 1 | Completion interrupt |

## Verification
The bench sweeps byte counts from one to nine in both directions. This walks every position of the final partial word, so it separates correct byte-enable and packing logic from off-by-one counting at the word edge. Counts of zero and counts above each ceiling separate the immediate-completion path and the two different clamps. Gaps are inserted into the memory and serial handshakes on differing cycle patterns, so a design that moves data without waiting for ready shows up as lost or repeated bytes. A second trigger during a run, and writes of 0 and 1 to the pending bit with the enable on and off, separate the ignore rule and the W1C rule from plain register storage.

// File: rtl/snand_dma_pkg.sv
package snand_dma_pkg;

    localparam logic [7:0] OFS_CFG   = 8'h00;
    localparam logic [7:0] OFS_TRIG  = 8'h18;
    localparam logic [7:0] OFS_ADDR  = 8'h1C;
    localparam logic [7:0] OFS_PEND  = 8'h20;
    localparam logic [7:0] OFS_LEN   = 8'h24;
    localparam logic [7:0] OFS_BUSY  = 8'h40;

    localparam int IRQ_EN_BIT = 20;
    localparam int WID_LSB    = 28;

    typedef enum logic {
        DIR_F2M = 1'b0,
        DIR_M2F = 1'b1
    } dir_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_MWR,
        ST_MRD,
        ST_DRAIN,
        ST_DONE
    } state_e;

    // Lane inside a word that stream byte position idx occupies (first byte high).
    function automatic logic [1:0] lane_of(input logic [1:0] idx);
        return ~idx;
    endfunction

endpackage

// File: rtl/snand_dma_regs.sv
module snand_dma_regs
    import snand_dma_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int RD_LIMIT = 2080,
    parameter int WR_LIMIT = 520
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             busy,
    input  logic             done,
    output logic             start,
    output dir_e             start_dir,
    output logic [29:0]      start_waddr,
    output logic [CNT_W-1:0] start_cnt,
    output logic [1:0]       start_wid,
    output logic             irq_en,
    output logic             pend,
    output logic             irq
);
    localparam logic [CNT_W-1:0] RD_CAP = CNT_W'(RD_LIMIT);
    localparam logic [CNT_W-1:0] WR_CAP = CNT_W'(WR_LIMIT);

    logic [31:0]      addr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       wid_q;
    logic [CNT_W-1:0] cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
            wid_q  <= '0;
            irq_en <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_CFG:  irq_en <= reg_wdata[IRQ_EN_BIT];
                OFS_ADDR: addr_q <= reg_wdata;
                OFS_LEN: begin
                    cnt_q <= reg_wdata[CNT_W-1:0];
                    wid_q <= reg_wdata[WID_LSB+1:WID_LSB];
                end
                default: ;
            endcase
        end
    end

    // Pending: completion sets it, a written 1 clears it; set wins a tie.
    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (done)
            pend <= 1'b1;
        else if (reg_wr && reg_addr == OFS_PEND && reg_wdata[0])
            pend <= 1'b0;
    end

    assign start       = reg_wr && (reg_addr == OFS_TRIG) && !busy;
    assign start_dir   = dir_e'(reg_wdata[0]);
    assign cap         = (start_dir == DIR_M2F) ? WR_CAP : RD_CAP;
    assign start_cnt   = (cnt_q > cap) ? cap : cnt_q;
    assign start_waddr = addr_q[31:2];
    assign start_wid   = wid_q;
    assign irq         = pend & irq_en;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CFG:  reg_rdata[IRQ_EN_BIT] = irq_en;
            OFS_ADDR: reg_rdata = addr_q;
            OFS_LEN: begin
                reg_rdata[CNT_W-1:0]          = cnt_q;
                reg_rdata[WID_LSB+1:WID_LSB]  = wid_q;
            end
            OFS_PEND: reg_rdata[0] = pend;
            OFS_BUSY: reg_rdata[3:1] = {3{busy}};
            default: ;
        endcase
    end

endmodule

// File: rtl/snand_dma_mover.sv
module snand_dma_mover
    import snand_dma_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  dir_e             start_dir,
    input  logic [29:0]      start_waddr,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic [1:0]       start_wid,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    output logic [3:0]       mem_be,
    input  logic             mem_ready,
    input  logic [31:0]      mem_rdata,
    input  logic             fl_rx_valid,
    input  logic [7:0]       fl_rx_data,
    output logic             fl_rx_ready,
    output logic             fl_tx_valid,
    output logic [7:0]       fl_tx_data,
    input  logic             fl_tx_ready,
    output logic             fl_own,
    output logic             fl_dir,
    output logic [1:0]       fl_width,
    output logic             busy,
    output logic             done
);
    state_e           st;
    dir_e             dir_q;
    logic [1:0]       wid_q;
    logic [29:0]      waddr;
    logic [CNT_W-1:0] rem;
    logic [1:0]       bidx;
    logic [31:0]      wbuf;
    logic [3:0]       wbe;
    logic [1:0]       lane;

    assign lane = lane_of(bidx);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            dir_q <= DIR_F2M;
            wid_q <= '0;
            waddr <= '0;
            rem   <= '0;
            bidx  <= '0;
            wbuf  <= '0;
            wbe   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    dir_q <= start_dir;
                    wid_q <= start_wid;
                    waddr <= start_waddr;
                    rem   <= start_cnt;
                    bidx  <= '0;
                    wbuf  <= '0;
                    wbe   <= '0;
                    if (start_cnt == '0)
                        st <= ST_DONE;
                    else if (start_dir == DIR_F2M)
                        st <= ST_FILL;
                    else
                        st <= ST_MRD;
                end
                ST_FILL: if (fl_rx_valid) begin
                    wbuf[{lane, 3'b000} +: 8] <= fl_rx_data;
                    wbe[lane] <= 1'b1;
                    rem       <= rem - 1'b1;
                    bidx      <= bidx + 1'b1;
                    if (bidx == 2'd3 || rem == CNT_W'(1))
                        st <= ST_MWR;
                end
                ST_MWR: if (mem_ready) begin
                    waddr <= waddr + 1'b1;
                    bidx  <= '0;
                    wbuf  <= '0;
                    wbe   <= '0;
                    st    <= (rem == '0) ? ST_DONE : ST_FILL;
                end
                ST_MRD: if (mem_ready) begin
                    wbuf <= mem_rdata;
                    bidx <= '0;
                    st   <= ST_DRAIN;
                end
                ST_DRAIN: if (fl_tx_ready) begin
                    rem  <= rem - 1'b1;
                    bidx <= bidx + 1'b1;
                    if (rem == CNT_W'(1))
                        st <= ST_DONE;
                    else if (bidx == 2'd3) begin
                        waddr <= waddr + 1'b1;
                        st    <= ST_MRD;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_req     = (st == ST_MWR) || (st == ST_MRD);
    assign mem_we      = (st == ST_MWR);
    assign mem_addr    = {waddr, 2'b00};
    assign mem_wdata   = wbuf;
    assign mem_be      = (st == ST_MWR) ? wbe : 4'hF;
    assign fl_rx_ready = (st == ST_FILL);
    assign fl_tx_valid = (st == ST_DRAIN);
    assign fl_tx_data  = wbuf[{lane, 3'b000} +: 8];
    assign busy        = (st != ST_IDLE);
    assign done        = (st == ST_DONE);
    assign fl_own      = busy;
    assign fl_dir      = dir_q;
    assign fl_width    = wid_q;

endmodule

// File: rtl/snand_dma.sv
module snand_dma
    import snand_dma_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int RD_LIMIT = 2080,
    parameter int WR_LIMIT = 520
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_be,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    input  logic        fl_rx_valid,
    input  logic [7:0]  fl_rx_data,
    output logic        fl_rx_ready,
    output logic        fl_tx_valid,
    output logic [7:0]  fl_tx_data,
    input  logic        fl_tx_ready,
    output logic        fl_own,
    output logic        fl_dir,
    output logic [1:0]  fl_width,
    output logic        irq
);
    logic             busy;
    logic             done;
    logic             start;
    dir_e             start_dir;
    logic [29:0]      start_waddr;
    logic [CNT_W-1:0] start_cnt;
    logic [1:0]       start_wid;
    logic             irq_en;
    logic             pend;

    snand_dma_regs #(
        .CNT_W(CNT_W), .RD_LIMIT(RD_LIMIT), .WR_LIMIT(WR_LIMIT)
    ) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy(busy), .done(done),
        .start(start), .start_dir(start_dir), .start_waddr(start_waddr),
        .start_cnt(start_cnt), .start_wid(start_wid),
        .irq_en(irq_en), .pend(pend), .irq(irq)
    );

    snand_dma_mover #(.CNT_W(CNT_W)) u_mover (
        .clk(clk), .rst(rst),
        .start(start), .start_dir(start_dir), .start_waddr(start_waddr),
        .start_cnt(start_cnt), .start_wid(start_wid),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata),
        .fl_rx_valid(fl_rx_valid), .fl_rx_data(fl_rx_data), .fl_rx_ready(fl_rx_ready),
        .fl_tx_valid(fl_tx_valid), .fl_tx_data(fl_tx_data), .fl_tx_ready(fl_tx_ready),
        .fl_own(fl_own), .fl_dir(fl_dir), .fl_width(fl_width),
        .busy(busy), .done(done)
    );

endmodule

// File: rtl/snand_dma_chk.sv
module snand_dma_chk
    import snand_dma_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic        mem_ready,
    input logic        fl_rx_ready,
    input logic        fl_tx_valid,
    input logic        fl_dir,
    input logic        fl_own,
    input logic        done,
    input logic        irq_en,
    input logic        pend,
    input logic        irq
);
    // R9
    done_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (done && irq_en && !(reg_wr && reg_addr == OFS_CFG)) |=> irq);

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !(reg_wr && reg_addr == OFS_PEND && reg_wdata[0])) |=> pend);

    // R4
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5
    be_live_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_be != 4'h0));

    // R11
    retrig_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_own && !done && reg_wr && reg_addr == OFS_TRIG) |=> $stable(fl_dir));

    // R3
    one_side_chk: assert property (@(posedge clk) disable iff (rst)
        fl_rx_ready |-> (!fl_tx_valid && !mem_req));
endmodule

bind snand_dma snand_dma_chk u_chk (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_ready(mem_ready),
    .fl_rx_ready(fl_rx_ready), .fl_tx_valid(fl_tx_valid),
    .fl_dir(fl_dir), .fl_own(fl_own), .done(done),
    .irq_en(irq_en), .pend(pend), .irq(irq)
);

// File: tb/sim_snand_dma.sv
module sim_snand_dma;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        fl_rx_valid = 1'b0;
    logic [7:0]  fl_rx_data = '0;
    logic        fl_rx_ready;
    logic        fl_tx_valid;
    logic [7:0]  fl_tx_data;
    logic        fl_tx_ready = 1'b0;
    logic        fl_own, fl_dir;
    logic [1:0]  fl_width;
    logic        irq;

    always #2 clk = ~clk;

    snand_dma u0 (.*);

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int nwr, nrd, nrx, ntx;
    logic [31:0] wr_addr [0:1023];
    logic [31:0] wr_data [0:1023];
    logic [3:0]  wr_be   [0:1023];
    logic [31:0] rd_addr [0:1023];
    logic [7:0]  tx_byte [0:1023];

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [7:0] rxb(input int k);
        return 8'(k * 13 + 5);
    endfunction

    // Bus and serial models: decide handshakes at the falling edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        mem_ready = (cyc % 3) != 1;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                if (nwr < 1024) begin
                    wr_addr[nwr] = mem_addr; wr_data[nwr] = mem_wdata; wr_be[nwr] = mem_be;
                end
                nwr++;
            end else begin
                mem_rdata = memf(mem_addr);
                if (nrd < 1024) rd_addr[nrd] = mem_addr;
                nrd++;
            end
        end
        fl_rx_valid = (cyc % 5) != 2;
        fl_rx_data  = rxb(nrx);
        if (fl_rx_valid && fl_rx_ready) nrx++;
        fl_tx_ready = (cyc % 4) != 3;
        if (fl_tx_valid && fl_tx_ready) begin
            if (ntx < 1024) tx_byte[ntx] = fl_tx_data;
            ntx++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 6000; i++) begin
            rd(8'h40, v);
            if (v == 0) break;
        end
    endtask

    task automatic run(input bit dir, input logic [31:0] base, input int len, input logic [1:0] wid);
        logic [31:0] v;
        int n, bad;
        logic [31:0] ew;
        logic [3:0]  eb;
        nwr = 0; nrd = 0; nrx = 0; ntx = 0;
        wr(8'h24, {2'b00, wid, 16'h0, 12'(len)});
        wr(8'h1C, base);
        wr(8'h18, {31'b0, dir});
        if (len != 0) begin
            rd(8'h40, v);
            chk(v == 32'hE, "R10 busy bits", v, 32'hE);
            chk(fl_width == wid && fl_dir == dir, "R13 lane/dir", {fl_width, fl_dir}, {wid, dir});
        end
        wait_idle();
        rd(8'h20, v);
        chk(v == 1, "R8 pending set", v, 1);
        if (dir == 1'b0) begin
            n = (len > 2080) ? 2080 : len;
            chk(nwr == (n + 3) / 4 && nrx == n, "R6 R12 f2m word/byte count", nwr, (n + 3) / 4);
            bad = 0;
            for (int i = 0; i < (n + 3) / 4 && i < 1024; i++) begin
                ew = '0; eb = '0;
                for (int j = 0; j < 4; j++)
                    if (4 * i + j < n) begin
                        ew[31 - 8 * j -: 8] = rxb(4 * i + j);
                        eb[3 - j] = 1'b1;
                    end
                if (wr_addr[i] != {base[31:2], 2'b00} + 32'(4 * i) || wr_data[i] != ew || wr_be[i] != eb) begin
                    if (bad == 0)
                        chk(1'b0, "R4 R5 f2m word", {wr_be[i], wr_data[i]}, {eb, ew});
                    bad++;
                end
            end
            if (bad == 0) chk(1'b1, "R4 R5", 0, 0);
        end else begin
            n = (len > 520) ? 520 : len;
            chk(ntx == n && nrd == (n + 3) / 4, "R7 R12 m2f byte count", ntx, n);
            bad = 0;
            for (int k = 0; k < n && k < 1024; k++) begin
                ew = memf({base[31:2], 2'b00} + 32'(4 * (k / 4)));
                if (tx_byte[k] != ew[31 - 8 * (k % 4) -: 8]) begin
                    if (bad == 0)
                        chk(1'b0, "R4 m2f byte", tx_byte[k], ew[31 - 8 * (k % 4) -: 8]);
                    bad++;
                end
            end
            if (bad == 0) chk(1'b1, "R4", 0, 0);
        end
        wr(8'h20, 32'h1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        nwr = 0; nrd = 0; nrx = 0; ntx = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(irq == 0 && mem_req == 0 && fl_rx_ready == 0 && fl_tx_valid == 0, "R1 outputs", irq, 0);
        rd(8'h00, v); chk(v == 0, "R1 cfg", v, 0);
        rd(8'h1C, v); chk(v == 0, "R1 addr", v, 0);
        rd(8'h24, v); chk(v == 0, "R1 len", v, 0);
        rd(8'h20, v); chk(v == 0, "R1 pending", v, 0);
        rd(8'h40, v); chk(v == 0, "R1 busy", v, 0);
        // R2 readback
        wr(8'h1C, 32'hDEAD_BEE7); rd(8'h1C, v); chk(v == 32'hDEAD_BEE7, "R2 addr", v, 32'hDEAD_BEE7);
        wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, v); chk(v == 32'h3000_0FFF, "R2 len", v, 32'h3000_0FFF);
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk(v == 32'h0010_0000, "R2 cfg", v, 32'h0010_0000);
        wr(8'h00, 32'h0);
        // R3 both directions swept over every final-word fill
        for (int len = 1; len <= 9; len++) begin
            run(1'b0, 32'h1000_0000 + 32'(len * 64), len, 2'(len % 3));
            run(1'b1, 32'h2000_0003 + 32'(len * 64), len, 2'(len % 3));
        end
        // R12 zero length
        run(1'b0, 32'h3000_0000, 0, 2'd0);
        run(1'b1, 32'h3000_0100, 0, 2'd1);
        // R6 / R7 clamps
        run(1'b0, 32'h4000_0000, 2100, 2'd2);
        run(1'b1, 32'h5000_0000, 600, 2'd1);
        run(1'b0, 32'h4800_0000, 2080, 2'd1);
        // R8 / R9 W1C and interrupt gating
        wr(8'h00, 32'h0010_0000);
        run(1'b1, 32'h6000_0000, 5, 2'd0);
        wr(8'h24, 32'd3); wr(8'h18, 32'd0); wait_idle();
        @(negedge clk); chk(irq == 1, "R9 irq on", irq, 1);
        wr(8'h20, 32'h0); rd(8'h20, v); chk(v == 1, "R8 write 0 keeps", v, 1);
        wr(8'h00, 32'h0); @(negedge clk); chk(irq == 0, "R9 irq gated", irq, 0);
        wr(8'h00, 32'h0010_0000); @(negedge clk); chk(irq == 1, "R9 irq regated", irq, 1);
        wr(8'h20, 32'h1); rd(8'h20, v); chk(v == 0, "R8 write 1 clears", v, 0);
        @(negedge clk); chk(irq == 0, "R9 irq after clear", irq, 0);
        wr(8'h00, 32'h0);
        // R11 retrigger ignored
        nwr = 0; nrd = 0; nrx = 0; ntx = 0;
        wr(8'h24, 32'd40); wr(8'h1C, 32'h7000_0000); wr(8'h18, 32'd1);
        wr(8'h24, 32'd8); wr(8'h18, 32'd0);
        chk(fl_dir == 1'b1, "R11 dir kept", fl_dir, 1);
        wait_idle();
        chk(ntx == 40 && nrx == 0 && nwr == 0, "R11 run unchanged", ntx, 40);
        finish_run();
    end
endmodule